// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block keeps the interrupt state of a single 8-bit timer/counter: an enable mask, a status register with a compare-match flag and an overflow flag, and a self-clearing control bit that restarts the timer's prescaler. The counter, comparator and prescaler sit outside. They send single-cycle event strobes in and receive a one-cycle prescaler restart pulse back.

Software reads and writes the three registers through a small synchronous write port and a combinational read port. A status flag can be cleared in two ways: by writing a one to its bit, or by the interrupt controller's acknowledge strobe when it takes the matching vector. An interrupt request line is high only while the global enable, the bit's own enable and the flag are all set.

When the counter runs in PWM (up/down) mode, the overflow flag follows the turn from counting down to counting up at zero, not the wrap. If the timer is clocked from an asynchronous source, the prescaler restart bit reads back as one until the prescaler reports completion. With the synchronous clock it always reads as zero.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After synchronous reset, all three registers read zero, both request lines are low and the restart pulse is low. Register select codes are 0 for mask, 1 for status, 2 for control and 3 for none (reads zero, writes ignored).
- R2: A compare-match strobe sets status bit 7 on the next clock edge.
- R3: Outside PWM mode, a wrap strobe sets status bit 6 and a bottom-turn strobe has no effect. In PWM mode, a bottom-turn strobe sets status bit 6 and a wrap strobe has no effect.
- R4: Writing a one to status bit 7 or bit 6 clears that flag. Writing a zero leaves it unchanged.
- R5: The match acknowledge clears status bit 7, and the overflow acknowledge clears status bit 6.
- R6: irq_match equals gie AND mask bit 7 AND status bit 7. irq_ovf equals gie AND mask bit 6 AND status bit 6.
- R7: Writing control with bit 1 set drives psr_pulse high for exactly the next cycle. Writing control with bit 1 clear produces no pulse.
- R8: While async_mode is low, control bit 1 reads as zero.
- R9: While async_mode is high, control bit 1 reads one from the cycle after a restart write until the cycle after psr_done. A new write in the same cycle as psr_done keeps it set.
- R10: If a set strobe and a clear (by write or by acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R11: Mask bits 7 to 0 and status bits 5 to 0 are plain storage that reads back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register written (0 mask, 1 status, 2 control) |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register read (same codes) |
| rd_data | output | 8 | Combinational readback |
| gie | input | 1 | Global interrupt enable |
| pwm_mode | input | 1 | Counter is in up/down PWM mode |
| ev_match | input | 1 | Compare-match strobe |
| ev_wrap | input | 1 | Counter wrap strobe |
| ev_bottom | input | 1 | Down-to-up turn at zero strobe |
| ack_match | input | 1 | Controller took the match vector |
| ack_ovf | input | 1 | Controller took the overflow vector |
| async_mode | input | 1 | Timer clocked from asynchronous source |
| psr_done | input | 1 | Prescaler restart completed (synchronized pulse) |
| irq_match | output | 1 | Compare-match interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| psr_pulse | output | 1 | One-cycle prescaler restart |

## Verification
A flag that is stuck or dropped shows up on the status readback and, when enabled, on the request line one edge after the strobe that should have moved it. A wrong mode select for the overflow source shows up the same way on the first wrap or bottom strobe. Bad restart state shows up either as an extra or missing psr_pulse in the cycle after a control write, or as control bit 1 reading one in synchronous mode or clearing early in asynchronous mode. Random traffic runs against a cycle model, and directed cases cover same-cycle set/clear collisions and the restart handshake.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    localparam int DW     = 8;
    localparam int NSRC   = 2;
    localparam int SEL_W  = 2;
    localparam int LOW_W  = DW - NSRC;
    localparam int PSR_BIT = 1;

    // source index 0 = compare match, 1 = overflow
    localparam int SRC_MATCH = 0;
    localparam int SRC_OVF   = 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_MASK = 2'd0,
        SEL_FLAG = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic mask;
        logic flag;
        logic ctrl;
    } wr_dec_t;

    // status / mask bit position of a source
    function automatic int src_bit(input int src);
        return DW - 1 - src;
    endfunction

    function automatic wr_dec_t decode_wr(input logic en, input logic [SEL_W-1:0] sel);
        wr_dec_t d;
        d.mask = en && (reg_sel_e'(sel) == SEL_MASK);
        d.flag = en && (reg_sel_e'(sel) == SEL_FLAG);
        d.ctrl = en && (reg_sel_e'(sel) == SEL_CTRL);
        return d;
    endfunction

endpackage

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
    parameter int DW   = tmr_irq_pkg::DW,
    parameter int NSRC = tmr_irq_pkg::NSRC,
    localparam int LOW_W = DW - NSRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  set_i,
    input  logic [NSRC-1:0]  clr_i,
    input  logic             wr_low,
    input  logic [LOW_W-1:0] low_data,
    output logic [NSRC-1:0]  flag_o,
    output logic [LOW_W-1:0] low_o
);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else
                q <= set_i[s] | (q & ~clr_i[s]);   // set has priority
        end
        assign flag_o[s] = q;
    end

    logic [LOW_W-1:0] low_q;
    always_ff @(posedge clk) begin
        if (rst)
            low_q <= '0;
        else if (wr_low)
            low_q <= low_data;
    end
    assign low_o = low_q;

endmodule

// File: rtl/tmr_irq_mask.sv
module tmr_irq_mask #(
    parameter int DW   = tmr_irq_pkg::DW,
    parameter int NSRC = tmr_irq_pkg::NSRC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [DW-1:0]   wr_data,
    input  logic            gie,
    input  logic [NSRC-1:0] flag_i,
    output logic [DW-1:0]   mask_o,
    output logic [NSRC-1:0] irq_o
);

    logic [DW-1:0] mask_q;
    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (wr)
            mask_q <= wr_data;
    end
    assign mask_o = mask_q;

    for (genvar s = 0; s < NSRC; s++) begin : g_irq
        assign irq_o[s] = gie & mask_q[DW-1-s] & flag_i[s];
    end

endmodule

// File: rtl/tmr_irq_psr.sv
module tmr_irq_psr (
    input  logic clk,
    input  logic rst,
    input  logic wr_one,
    input  logic async_mode,
    input  logic done,
    output logic pulse_o,
    output logic pend_o,
    output logic rd_bit
);

    logic pulse_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            pulse_q <= wr_one;
            if (async_mode)
                pend_q <= wr_one | (pend_q & ~done);
            else
                pend_q <= 1'b0;
        end
    end

    assign pulse_o = pulse_q;
    assign pend_o  = pend_q;
    assign rd_bit  = async_mode & pend_q;

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import tmr_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [DW-1:0]    rd_data,
    input  logic             gie,
    input  logic             pwm_mode,
    input  logic             ev_match,
    input  logic             ev_wrap,
    input  logic             ev_bottom,
    input  logic             ack_match,
    input  logic             ack_ovf,
    input  logic             async_mode,
    input  logic             psr_done,
    output logic             irq_match,
    output logic             irq_ovf,
    output logic             psr_pulse
);

    wr_dec_t          wdec;
    logic [NSRC-1:0]  set_v;
    logic [NSRC-1:0]  clr_v;
    logic [NSRC-1:0]  ack_v;
    logic [NSRC-1:0]  flag_vec;
    logic [NSRC-1:0]  irq_v;
    logic [LOW_W-1:0] low_q;
    logic [DW-1:0]    mask_q;
    logic             psr_pend;
    logic             psr_rd;

    assign wdec = decode_wr(wr_en, wr_sel);

    assign set_v[SRC_MATCH] = ev_match;
    assign set_v[SRC_OVF]   = pwm_mode ? ev_bottom : ev_wrap;
    assign ack_v[SRC_MATCH] = ack_match;
    assign ack_v[SRC_OVF]   = ack_ovf;

    for (genvar s = 0; s < NSRC; s++) begin : g_clr
        assign clr_v[s] = (wdec.flag & wr_data[DW-1-s]) | ack_v[s];
    end

    tmr_irq_flags #(.DW(DW), .NSRC(NSRC)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_v),
        .clr_i    (clr_v),
        .wr_low   (wdec.flag),
        .low_data (wr_data[LOW_W-1:0]),
        .flag_o   (flag_vec),
        .low_o    (low_q)
    );

    tmr_irq_mask #(.DW(DW), .NSRC(NSRC)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr      (wdec.mask),
        .wr_data (wr_data),
        .gie     (gie),
        .flag_i  (flag_vec),
        .mask_o  (mask_q),
        .irq_o   (irq_v)
    );

    tmr_irq_psr u_psr (
        .clk        (clk),
        .rst        (rst),
        .wr_one     (wdec.ctrl & wr_data[PSR_BIT]),
        .async_mode (async_mode),
        .done       (psr_done),
        .pulse_o    (psr_pulse),
        .pend_o     (psr_pend),
        .rd_bit     (psr_rd)
    );

    assign irq_match = irq_v[SRC_MATCH];
    assign irq_ovf   = irq_v[SRC_OVF];

    logic [DW-1:0] flag_word;
    always_comb begin
        flag_word = {{NSRC{1'b0}}, low_q};
        for (int s = 0; s < NSRC; s++)
            flag_word[DW-1-s] = flag_vec[s];
    end

    always_comb begin
        rd_data = '0;
        unique case (reg_sel_e'(rd_sel))
            SEL_MASK: rd_data = mask_q;
            SEL_FLAG: rd_data = flag_word;
            SEL_CTRL: rd_data[PSR_BIT] = psr_rd;
            SEL_NONE: rd_data = '0;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk
    import tmr_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic [DW-1:0]    wr_data,
    input logic [SEL_W-1:0] rd_sel,
    input logic [DW-1:0]    rd_data,
    input logic             gie,
    input logic             pwm_mode,
    input logic             ev_match,
    input logic             ev_wrap,
    input logic             ev_bottom,
    input logic             ack_match,
    input logic             ack_ovf,
    input logic             async_mode,
    input logic             psr_done,
    input logic             irq_match,
    input logic             irq_ovf,
    input logic             psr_pulse,
    input logic [NSRC-1:0]  flag_vec,
    input logic [DW-1:0]    mask_q,
    input logic             psr_pend
);

    logic flag_wr;
    assign flag_wr = wr_en && (wr_sel == 2'd1);

    assert_match_set_R2: assert property (@(posedge clk) disable iff (rst)
        ev_match |=> flag_vec[0]);

    assert_pwm_bottom_R3: assert property (@(posedge clk) disable iff (rst)
        (pwm_mode && ev_bottom) |=> flag_vec[1]);

    assert_pwm_wrap_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (pwm_mode && !ev_bottom && !flag_vec[1]) |=> !flag_vec[1]);

    assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && wr_data[7] && !ev_match) |=> !flag_vec[0]);

    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (ack_ovf && !(pwm_mode ? ev_bottom : ev_wrap)) |=> !flag_vec[1]);

    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_match || irq_ovf) |-> gie);

    assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && wr_data[1]) |=> psr_pulse);

    assert_sync_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (!async_mode && rd_sel == 2'd2) |-> (rd_data[1] == 1'b0));

    assert_async_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (async_mode && psr_pend && !psr_done) |=> psr_pend);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (ev_match && ack_match) |=> flag_vec[0]);

endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk u_chk (.*);

// File: tb/tmr_irq_ctrl_bench.sv
module tmr_irq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [1:0] wr_sel;
    logic [7:0] wr_data;
    logic [1:0] rd_sel;
    logic [7:0] rd_data;
    logic       gie, pwm_mode, ev_match, ev_wrap, ev_bottom;
    logic       ack_match, ack_ovf, async_mode, psr_done;
    logic       irq_match, irq_ovf, psr_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // bench model state
    logic       m_f7, m_f6, m_pend, m_pulse;
    logic [5:0] m_low;
    logic [7:0] m_mask;

    always #10 clk = ~clk;   // 50 MHz

    tmr_irq_ctrl u_tmr_irq_ctrl (.*);

    function automatic logic [7:0] exp_rd(input logic [1:0] sel);
        case (sel)
            2'd0:    return m_mask;
            2'd1:    return {m_f7, m_f6, m_low};
            2'd2:    return {6'b0, async_mode & m_pend, 1'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_sel = 0; wr_data = 0; ev_match = 0; ev_wrap = 0;
        ev_bottom = 0; ack_match = 0; ack_ovf = 0; psr_done = 0;
    endtask

    // inputs are already driven; advance one cycle and check against model
    task automatic step(input string tag);
        logic wf, wm, wpsr, so, cm, co;
        logic n7, n6, np;
        wf   = wr_en && wr_sel == 2'd1;
        wm   = wr_en && wr_sel == 2'd0;
        wpsr = wr_en && wr_sel == 2'd2 && wr_data[1];
        so   = pwm_mode ? ev_bottom : ev_wrap;
        cm   = (wf && wr_data[7]) || ack_match;
        co   = (wf && wr_data[6]) || ack_ovf;
        n7   = ev_match | (m_f7 & ~cm);
        n6   = so | (m_f6 & ~co);
        np   = async_mode ? (wpsr | (m_pend & ~psr_done)) : 1'b0;
        @(posedge clk);
        @(negedge clk);
        m_f7 = n7; m_f6 = n6; m_pend = np; m_pulse = wpsr;
        if (wf) m_low = wr_data[5:0];
        if (wm) m_mask = wr_data;
        check(tag, rd_data, exp_rd(rd_sel));
        check("R6 irq_match", {7'b0, irq_match}, {7'b0, gie & m_mask[7] & m_f7});
        check("R6 irq_ovf",   {7'b0, irq_ovf},   {7'b0, gie & m_mask[6] & m_f6});
        check("R7 psr_pulse", {7'b0, psr_pulse}, {7'b0, m_pulse});
        idle();
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        rst = 1; gie = 0; pwm_mode = 0; async_mode = 0; rd_sel = 0;
        m_f7 = 0; m_f6 = 0; m_pend = 0; m_pulse = 0; m_low = 0; m_mask = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1 check("R1 reset readback", rd_data, 8'h00);
        end
        check("R1 reset irq", {6'b0, irq_match, irq_ovf}, 8'h00);
        check("R1 reset pulse", {7'b0, psr_pulse}, 8'h00);

        // R11 storage
        rd_sel = 0; wr(2'd0, 8'hA5); step("R11 mask storage");
        rd_sel = 1; wr(2'd1, 8'h2B); step("R11 low status storage");
        // R2 match set, R6 gating
        gie = 1; wr(2'd0, 8'hC0); step("R11 mask");
        rd_sel = 1; ev_match = 1; step("R2 match sets bit7");
        // R4 write zero no effect, write one clears
        wr(2'd1, 8'h00); step("R4 write zero keeps flag");
        wr(2'd1, 8'h80); step("R4 write one clears");
        // R3 normal mode
        ev_bottom = 1; step("R3 bottom ignored in normal mode");
        ev_wrap = 1; step("R3 wrap sets bit6");
        ack_ovf = 1; step("R5 ack clears ovf");
        pwm_mode = 1; ev_wrap = 1; step("R3 wrap ignored in pwm");
        ev_bottom = 1; step("R3 bottom sets in pwm");
        // R10 set wins
        ev_bottom = 1; wr(2'd1, 8'hC0); step("R10 set beats write clear");
        ev_match = 1; ack_match = 1; step("R10 set beats ack");
        ack_match = 1; step("R5 ack clears match");
        gie = 0; step("R6 gie low masks");
        // R7/R8 sync
        rd_sel = 2; wr(2'd2, 8'h02); step("R8 sync reads zero");
        wr(2'd2, 8'hFD); step("R7 write zero no pulse");
        // R9 async
        async_mode = 1; wr(2'd2, 8'h02); step("R9 async set");
        step("R9 async holds");
        psr_done = 1; step("R9 done clears");
        wr(2'd2, 8'h02); step("R9 set again");
        psr_done = 1; wr(2'd2, 8'h02); step("R9 write beats done");
        psr_done = 1; step("R9 cleared");

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 63) == 0) pwm_mode = ~pwm_mode;
            if ($urandom_range(0, 63) == 0) async_mode = ~async_mode;
            gie       = ($urandom_range(0, 7) != 0);
            ev_match  = ($urandom_range(0, 5) == 0);
            ev_wrap   = ($urandom_range(0, 5) == 0);
            ev_bottom = ($urandom_range(0, 5) == 0);
            ack_match = ($urandom_range(0, 7) == 0);
            ack_ovf   = ($urandom_range(0, 7) == 0);
            psr_done  = ($urandom_range(0, 5) == 0);
            rd_sel    = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0)
                wr(2'($urandom_range(0, 3)), 8'($urandom));
            step("R2/R3/R4/R5/R9/R10/R11 random readback");
        end

        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule